// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block walks the source and destination addresses of one DMA descriptor and keeps a live count of the bytes still to move. A descriptor is taken in on a one-cycle `load` pulse. It carries two start addresses, a length word, a stride word and per-side control bits. The data mover then asks for beats on two valid/ready channels, one for reads on the source side and one for writes on the destination side. Each accepted beat moves the matching address on by one step and uses up at most `BEAT_BYTES` bytes of that side's length.

In linear mode the length word is one byte count. In two-dimensional mode its upper field is a row count and its lower field is the bytes per row. After the last beat of each row, a signed, sign-extended per-side stride is added to that side's address. The beat channels are gated by two things: a wait counter, which inserts idle cycles after every accepted beat, and a selectable peripheral request line, which can hold back reads, writes or both.

Back-pressure rules on both beat channels:
- A beat is accepted only in a cycle where valid and ready are both high.
- Ready never depends on valid.
- Ready stays low while `load` is high, and once that side has used up its length.

Top module: `dma_agen_2d`

## Requirements
- R1: While reset is held and right after it, `done`, `row_end`, `rd_ready` and `wr_ready` are 0, both addresses and `remain` are 0, and `sel_req` is 1.
- R2: In the cycle after a `load` pulse, `src_addr` and `dst_addr` equal the start addresses. `remain` shows the length word: in linear mode, bits 29:0 as one byte count; in 2D mode, {rows (bits 29:16), bytes per row (bits 15:0)}.
- R3: Each accepted write beat lowers the destination byte count by min(4, bytes left in the row). `done` rises in the cycle after the write beat that brings the count to zero and stays high. While `done` is high, `wr_ready` is low.
- R4: On each accepted beat, a side whose increment bit is set advances its address by 4 at narrow width (wide bit 0) and by 32 at wide width (wide bit 1). A side whose increment bit is clear keeps its address.
- R5: In 2D mode each side performs Y rows of X bytes. After the last beat of a row, the address also gains the sign-extended 16-bit stride: destination from stride bits 31:16, source from bits 15:0. X then reloads and Y drops by one. `row_end` pulses for one cycle after each destination row ends, and in linear mode after the final beat.
- R6: A zero-length descriptor gives `done`=1 in the cycle after `load`, with `remain`=0 and both readies low. Zero length means a linear count of 0, or X=0 or Y=0 in 2D mode.
- R7: With a wait value N (0..31), both readies stay low for exactly N cycles after any accepted beat and return high in the next cycle. With N=0 there is no gap.
- R8: With select value 0, `sel_req` is 1. Otherwise `sel_req` equals `preq[select]`. While `sel_req` is 0, the source-gate bit holds `rd_ready` low and the destination-gate bit holds `wr_ready` low, each acting on its own.
- R9: The source side keeps its own count. Read beats leave `remain` unchanged, and `rd_ready` goes low once the source side has used up the length, even while writes are still pending.
- R10: A `load` during a transfer abandons it. The new descriptor's addresses and length show in the next cycle and `done` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle pulse that takes in a new descriptor |
| src_start | input | 32 | Source start address |
| dst_start | input | 32 | Destination start address |
| len_word | input | 30 | Length: rows in 29:16, bytes per row in 15:0 (one count in linear mode) |
| stride_word | input | 32 | Destination stride in 31:16, source stride in 15:0 (signed) |
| mode_2d | input | 1 | 1 = row/column mode, 0 = linear |
| src_inc | input | 1 | Source address advances per beat |
| dst_inc | input | 1 | Destination address advances per beat |
| src_wide | input | 1 | Source step 32 instead of 4 |
| dst_wide | input | 1 | Destination step 32 instead of 4 |
| wait_cycles | input | 5 | Idle cycles after each accepted beat |
| pace_sel | input | 5 | Request line select, 0 = unpaced |
| src_gate | input | 1 | Selected request gates reads |
| dst_gate | input | 1 | Selected request gates writes |
| preq | input | 32 | Peripheral request lines |
| rd_valid | input | 1 | Data mover offers a read beat |
| rd_ready | output | 1 | Read beat may proceed |
| wr_valid | input | 1 | Data mover offers a write beat |
| wr_ready | output | 1 | Write beat may proceed |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| remain | output | 30 | Bytes still to write (2D: {rows left, bytes left in row}) |
| row_end | output | 1 | One-cycle pulse after a destination row ends |
| done | output | 1 | Destination length used up |
| sel_req | output | 1 | State of the selected request line |

## Verification
Addresses, `remain`, `row_end` and `done` are registered. They are due in the cycle after the clock edge that accepts a beat or takes `load`. The readies and `sel_req` follow `preq` within the same cycle, and the wait gap starts in the cycle after an accepted beat. The driver records each expected post-beat state in a scoreboard queue at the accepting edge, and the monitor compares it at the next falling edge. Ready and request-line checks are sampled one nanosecond after the inputs change, away from any edge.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

  localparam int DEF_ADDR_W   = 32;
  localparam int DEF_X_W      = 16;
  localparam int DEF_Y_W      = 14;
  localparam int DEF_STRIDE_W = 16;
  localparam int DEF_NUM_REQ  = 32;
  localparam int DEF_WAIT_W   = 5;
  localparam int DEF_BEAT     = 4;
  localparam int DEF_STEP_N   = 4;
  localparam int DEF_STEP_W   = 32;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_DONE = 2'd2
  } walk_state_e;

endpackage

// File: rtl/dma_agen_pace.sv
module dma_agen_pace
  import dma_agen_pkg::*;
#(
  parameter int NUM_REQ = DEF_NUM_REQ,
  parameter int WAIT_W  = DEF_WAIT_W,
  localparam int SEL_W  = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SEL_W-1:0]   sel,
  input  logic [WAIT_W-1:0]  wait_cycles,
  input  logic               src_gate,
  input  logic               dst_gate,
  input  logic [NUM_REQ-1:0] preq,
  input  logic               rd_fire,
  input  logic               wr_fire,
  output logic               sel_req,
  output logic               rd_ok,
  output logic               wr_ok
);

  logic [SEL_W-1:0]  sel_q;
  logic              sgate_q;
  logic              dgate_q;
  logic [WAIT_W-1:0] wcfg_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic              idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      sgate_q <= 1'b0;
      dgate_q <= 1'b0;
      wcfg_q  <= '0;
      wcnt_q  <= '0;
    end else if (load) begin
      sel_q   <= sel;
      sgate_q <= src_gate;
      dgate_q <= dst_gate;
      wcfg_q  <= wait_cycles;
      wcnt_q  <= '0;
    end else if (rd_fire || wr_fire) begin
      wcnt_q  <= wcfg_q;
    end else if (wcnt_q != '0) begin
      wcnt_q  <= wcnt_q - 1'b1;
    end
  end

  assign sel_req = (sel_q == '0) ? 1'b1 : preq[sel_q];
  assign idle    = (wcnt_q == '0);
  assign rd_ok   = idle && (!sgate_q || sel_req);
  assign wr_ok   = idle && (!dgate_q || sel_req);

  // R7: a nonzero wait closes both channels in the cycle after a beat
  p_wait_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_fire || wr_fire) && (wcfg_q != '0)) |=> (!rd_ok && !wr_ok));

  // R8: gated reads never proceed against a low request line
  p_rd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sgate_q && !sel_req) |-> !rd_ok);

  // R8: gated writes never proceed against a low request line
  p_wr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dgate_q && !sel_req) |-> !wr_ok);

endmodule

// File: rtl/dma_agen_walker.sv
module dma_agen_walker
  import dma_agen_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int X_W         = DEF_X_W,
  parameter int Y_W         = DEF_Y_W,
  parameter int STRIDE_W    = DEF_STRIDE_W,
  parameter int BEAT_BYTES  = DEF_BEAT,
  parameter int NARROW_STEP = DEF_STEP_N,
  parameter int WIDE_STEP   = DEF_STEP_W,
  localparam int LIN_W      = X_W + Y_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [X_W-1:0]      len_x,
  input  logic [Y_W-1:0]      len_y,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                mode_2d,
  input  logic                inc,
  input  logic                wide,
  input  logic                pace_ok,
  input  logic                beat_valid,
  output logic                beat_ready,
  output logic [ADDR_W-1:0]   addr,
  output logic [LIN_W-1:0]    remain,
  output logic                row_end,
  output logic                done
);

  localparam logic [LIN_W-1:0]  BEAT_L = LIN_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(NARROW_STEP);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WIDE_STEP);

  walk_state_e         st_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LIN_W-1:0]    cnt_q;
  logic [Y_W-1:0]      rows_q;
  logic [X_W-1:0]      row_len_q;
  logic [STRIDE_W-1:0] stride_q;
  logic                mode_q;
  logic                inc_q;
  logic                wide_q;
  logic                row_end_q;

  logic                fire;
  logic [LIN_W-1:0]    take;
  logic [LIN_W-1:0]    cnt_after;
  logic                row_last;
  logic [ADDR_W-1:0]   step;
  logic [ADDR_W-1:0]   adj;
  logic [LIN_W-1:0]    load_total;
  logic                load_zero;

  // beat arithmetic
  always_comb begin
    fire       = beat_valid && beat_ready;
    take       = (cnt_q < BEAT_L) ? cnt_q : BEAT_L;
    cnt_after  = cnt_q - take;
    row_last   = (cnt_after == '0);
    step       = inc_q ? (wide_q ? STEP_W : STEP_N) : '0;
    adj        = (row_last && mode_q)
               ? {{(ADDR_W-STRIDE_W){stride_q[STRIDE_W-1]}}, stride_q}
               : '0;
    load_total = {len_y, len_x};
    load_zero  = mode_2d ? ((len_x == '0) || (len_y == '0))
                         : (load_total == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= WALK_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      rows_q    <= '0;
      row_len_q <= '0;
      stride_q  <= '0;
      mode_q    <= 1'b0;
      inc_q     <= 1'b0;
      wide_q    <= 1'b0;
      row_end_q <= 1'b0;
    end else if (load) begin
      addr_q    <= start_addr;
      row_len_q <= len_x;
      stride_q  <= stride;
      mode_q    <= mode_2d;
      inc_q     <= inc;
      wide_q    <= wide;
      row_end_q <= 1'b0;
      if (load_zero) begin
        st_q   <= WALK_DONE;
        cnt_q  <= '0;
        rows_q <= '0;
      end else begin
        st_q   <= WALK_RUN;
        cnt_q  <= mode_2d ? {{Y_W{1'b0}}, len_x} : load_total;
        rows_q <= mode_2d ? len_y : '0;
      end
    end else begin
      row_end_q <= 1'b0;
      if (fire) begin
        addr_q    <= addr_q + step + adj;
        row_end_q <= row_last;
        if (!row_last) begin
          cnt_q <= cnt_after;
        end else if (mode_q && (rows_q > 1)) begin
          rows_q <= rows_q - 1'b1;
          cnt_q  <= {{Y_W{1'b0}}, row_len_q};
        end else begin
          rows_q <= '0;
          cnt_q  <= '0;
          st_q   <= WALK_DONE;
        end
      end
    end
  end

  assign beat_ready = (st_q == WALK_RUN) && pace_ok && !load;
  assign addr       = addr_q;
  assign remain     = mode_q ? {rows_q, cnt_q[X_W-1:0]} : cnt_q;
  assign row_end    = row_end_q;
  assign done       = (st_q == WALK_DONE);

  // R3: a finished side offers no beats
  p_no_ready_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_ready);

  // R3: without a load the remaining count never grows
  p_remain_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (remain <= $past(remain)));

  // R4: a non-incrementing linear side holds its address across a beat
  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !inc_q && !mode_q) |=> $stable(addr));

  // R5: a row-end pulse always follows an accepted beat
  p_row_end_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> $past(fire));

  // R6: completion holds until the next descriptor
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

endmodule

// File: rtl/dma_agen_2d.sv
module dma_agen_2d
  import dma_agen_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int X_W         = DEF_X_W,
  parameter int Y_W         = DEF_Y_W,
  parameter int STRIDE_W    = DEF_STRIDE_W,
  parameter int NUM_REQ     = DEF_NUM_REQ,
  parameter int WAIT_W      = DEF_WAIT_W,
  parameter int BEAT_BYTES  = DEF_BEAT,
  parameter int NARROW_STEP = DEF_STEP_N,
  parameter int WIDE_STEP   = DEF_STEP_W,
  localparam int SEL_W      = $clog2(NUM_REQ),
  localparam int LIN_W      = X_W + Y_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     src_start,
  input  logic [ADDR_W-1:0]     dst_start,
  input  logic [LIN_W-1:0]      len_word,
  input  logic [2*STRIDE_W-1:0] stride_word,
  input  logic                  mode_2d,
  input  logic                  src_inc,
  input  logic                  dst_inc,
  input  logic                  src_wide,
  input  logic                  dst_wide,
  input  logic [WAIT_W-1:0]     wait_cycles,
  input  logic [SEL_W-1:0]      pace_sel,
  input  logic                  src_gate,
  input  logic                  dst_gate,
  input  logic [NUM_REQ-1:0]    preq,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  output logic [ADDR_W-1:0]     src_addr,
  output logic [ADDR_W-1:0]     dst_addr,
  output logic [LIN_W-1:0]      remain,
  output logic                  row_end,
  output logic                  done,
  output logic                  sel_req
);

  localparam int NSIDE = 2;  // index 0 = source, 1 = destination

  logic [ADDR_W-1:0]   side_start  [NSIDE];
  logic [STRIDE_W-1:0] side_stride [NSIDE];
  logic                side_inc    [NSIDE];
  logic                side_wide   [NSIDE];
  logic                side_ok     [NSIDE];
  logic                side_valid  [NSIDE];
  logic                side_ready  [NSIDE];
  logic [ADDR_W-1:0]   side_addr   [NSIDE];
  logic [LIN_W-1:0]    side_rem    [NSIDE];
  logic                side_rend   [NSIDE];
  logic                side_done   [NSIDE];
  logic                rd_ok;
  logic                wr_ok;
  logic                src_status_unused;

  assign side_start[0]  = src_start;
  assign side_start[1]  = dst_start;
  assign side_stride[0] = stride_word[STRIDE_W-1:0];
  assign side_stride[1] = stride_word[2*STRIDE_W-1:STRIDE_W];
  assign side_inc[0]    = src_inc;
  assign side_inc[1]    = dst_inc;
  assign side_wide[0]   = src_wide;
  assign side_wide[1]   = dst_wide;
  assign side_ok[0]     = rd_ok;
  assign side_ok[1]     = wr_ok;
  assign side_valid[0]  = rd_valid;
  assign side_valid[1]  = wr_valid;

  dma_agen_pace #(
    .NUM_REQ (NUM_REQ),
    .WAIT_W  (WAIT_W)
  ) u_pace (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .sel         (pace_sel),
    .wait_cycles (wait_cycles),
    .src_gate    (src_gate),
    .dst_gate    (dst_gate),
    .preq        (preq),
    .rd_fire     (rd_valid && rd_ready),
    .wr_fire     (wr_valid && wr_ready),
    .sel_req     (sel_req),
    .rd_ok       (rd_ok),
    .wr_ok       (wr_ok)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_agen_walker #(
      .ADDR_W      (ADDR_W),
      .X_W         (X_W),
      .Y_W         (Y_W),
      .STRIDE_W    (STRIDE_W),
      .BEAT_BYTES  (BEAT_BYTES),
      .NARROW_STEP (NARROW_STEP),
      .WIDE_STEP   (WIDE_STEP)
    ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start_addr (side_start[g]),
      .len_x      (len_word[X_W-1:0]),
      .len_y      (len_word[LIN_W-1:X_W]),
      .stride     (side_stride[g]),
      .mode_2d    (mode_2d),
      .inc        (side_inc[g]),
      .wide       (side_wide[g]),
      .pace_ok    (side_ok[g]),
      .beat_valid (side_valid[g]),
      .beat_ready (side_ready[g]),
      .addr       (side_addr[g]),
      .remain     (side_rem[g]),
      .row_end    (side_rend[g]),
      .done       (side_done[g])
    );
  end

  assign rd_ready = side_ready[0];
  assign wr_ready = side_ready[1];
  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];
  assign remain   = side_rem[1];
  assign row_end  = side_rend[1];
  assign done     = side_done[1];

  assign src_status_unused = ^{side_rem[0], side_rend[0], side_done[0]};

endmodule

// File: tb/dma_agen_2d_tb.sv
module dma_agen_2d_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] src_start = '0, dst_start = '0;
  logic [29:0] len_word = '0;
  logic [31:0] stride_word = '0;
  logic        mode_2d = 1'b0, src_inc = 1'b0, dst_inc = 1'b0;
  logic        src_wide = 1'b0, dst_wide = 1'b0;
  logic [4:0]  wait_cycles = '0, pace_sel = '0;
  logic        src_gate = 1'b0, dst_gate = 1'b0;
  logic [31:0] preq = '0;
  logic        rd_valid = 1'b0, wr_valid = 1'b0;
  logic        rd_ready, wr_ready, row_end, done, sel_req;
  logic [31:0] src_addr, dst_addr;
  logic [29:0] remain;

  always #5 clk = ~clk;

  dma_agen_2d u_dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_start(src_start), .dst_start(dst_start),
    .len_word(len_word), .stride_word(stride_word),
    .mode_2d(mode_2d), .src_inc(src_inc), .dst_inc(dst_inc),
    .src_wide(src_wide), .dst_wide(dst_wide),
    .wait_cycles(wait_cycles), .pace_sel(pace_sel),
    .src_gate(src_gate), .dst_gate(dst_gate), .preq(preq),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .remain(remain), .row_end(row_end), .done(done), .sel_req(sel_req)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          is_wr;
    logic [31:0] addr;
    logic [29:0] rem;
    bit          rend;
    bit          dn;
    string       req;
  } exp_t;

  exp_t sb[$];

  // reference model, per side: 0 = source, 1 = destination
  logic [31:0] m_a [2];
  logic [29:0] m_c [2];
  logic [13:0] m_r [2];
  bit          m_done [2];
  bit          m_inc [2], m_wide [2];
  logic [15:0] m_str [2];
  bit          m_2d;
  logic [15:0] m_rowlen;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] m_rem();
    return m_2d ? {m_r[1], m_c[1][15:0]} : m_c[1];
  endfunction

  task automatic m_step(input int s, output bit rend);
    logic [29:0] take;
    take = (m_c[s] < 30'd4) ? m_c[s] : 30'd4;
    m_c[s] = m_c[s] - take;
    m_a[s] = m_a[s] + (m_inc[s] ? (m_wide[s] ? 32'd32 : 32'd4) : 32'd0);
    rend = 1'b0;
    if (m_c[s] == '0) begin
      rend = 1'b1;
      if (m_2d) m_a[s] = m_a[s] + {{16{m_str[s][15]}}, m_str[s]};
      if (m_2d && m_r[s] > 14'd1) begin
        m_r[s] = m_r[s] - 14'd1;
        m_c[s] = {14'd0, m_rowlen};
      end else begin
        m_r[s] = '0;
        m_done[s] = 1'b1;
      end
    end
  endtask

  task automatic desc(input logic [31:0] s, input logic [31:0] d,
                      input logic [29:0] len, input logic [31:0] strd,
                      input bit two, input bit si, input bit sw,
                      input bit di, input bit dw, input logic [4:0] wt,
                      input logic [4:0] sel, input bit sg, input bit dg,
                      input string req);
    bit zero;
    @(negedge clk);
    src_start = s; dst_start = d; len_word = len; stride_word = strd;
    mode_2d = two; src_inc = si; src_wide = sw; dst_inc = di; dst_wide = dw;
    wait_cycles = wt; pace_sel = sel; src_gate = sg; dst_gate = dg;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    m_2d = two; m_rowlen = len[15:0];
    m_inc[0] = si; m_wide[0] = sw; m_str[0] = strd[15:0];
    m_inc[1] = di; m_wide[1] = dw; m_str[1] = strd[31:16];
    zero = two ? (len[15:0] == 0 || len[29:16] == 0) : (len == 0);
    for (int k = 0; k < 2; k++) begin
      m_a[k] = (k == 0) ? s : d;
      m_c[k] = zero ? 30'd0 : (two ? {14'd0, len[15:0]} : len);
      m_r[k] = (zero || !two) ? 14'd0 : len[29:16];
      m_done[k] = zero;
    end
    chk(req, "src_addr after load", src_addr, m_a[0]);
    chk(req, "dst_addr after load", dst_addr, m_a[1]);
    chk(req, "remain after load", {2'b0, remain}, {2'b0, m_rem()});
    chk(req, "done after load", {31'd0, done}, {31'd0, m_done[1]});
  endtask

  task automatic beat(input int s, input string req);
    exp_t e;
    bit rend;
    if (s == 0) rd_valid = 1'b1; else wr_valid = 1'b1;
    #1;
    while (((s == 0) ? rd_ready : wr_ready) !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    m_step(s, rend);
    e.is_wr = (s == 1);
    e.addr  = m_a[s];
    e.rem   = m_rem();
    e.rend  = (s == 1) ? rend : 1'b0;
    e.dn    = m_done[1];
    e.req   = req;
    sb.push_back(e);
    #1;
    if (s == 0) rd_valid = 1'b0; else wr_valid = 1'b0;
  endtask

  // monitor: compare the state due one cycle after each accepted beat
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.is_wr) chk(e.req, "dst_addr", dst_addr, e.addr);
      else         chk(e.req, "src_addr", src_addr, e.addr);
      chk(e.req, "remain", {2'b0, remain}, {2'b0, e.rem});
      chk(e.req, "row_end", {31'd0, row_end}, {31'd0, e.rend});
      chk(e.req, "done", {31'd0, done}, {31'd0, e.dn});
    end
  end

  task automatic ready_chk(input string req, input bit er, input bit ew);
    chk(req, "rd_ready", {31'd0, rd_ready}, {31'd0, er});
    chk(req, "wr_ready", {31'd0, wr_ready}, {31'd0, ew});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "src_addr", src_addr, 32'd0);
    chk("R1", "dst_addr", dst_addr, 32'd0);
    chk("R1", "remain", {2'b0, remain}, 32'd0);
    chk("R1", "row_end", {31'd0, row_end}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "sel_req", {31'd0, sel_req}, 32'd1);
    ready_chk("R1", 1'b0, 1'b0);

    // R2 R3 R4: linear, 10 bytes, narrow steps on both sides
    desc(32'h1000, 32'h2000, 30'd10, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      beat(0, "R4");
      beat(1, "R3");
    end
    @(negedge clk); #1;
    ready_chk("R3", 1'b0, 1'b0);
    chk("R3", "done held", {31'd0, done}, 32'd1);

    // R9: reads use up their own count first
    desc(32'h0A00, 32'h0B00, 30'd8, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R2");
    beat(0, "R9");
    beat(0, "R9");
    @(negedge clk); #1;
    ready_chk("R9", 1'b0, 1'b1);
    beat(1, "R9");
    beat(1, "R9");

    // R4: wide source step, fixed destination
    desc(32'h4000, 32'h5000, 30'd12, 32'd0, 0, 1, 1, 0, 0, 5'd0, 5'd0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      beat(0, "R4");
      beat(1, "R4");
    end

    // R5: 3 rows of 6 bytes, src stride +16, dst stride -4, dst wide
    desc(32'h0100, 32'h8000, {14'd3, 16'd6}, {16'hFFFC, 16'h0010},
         1, 1, 0, 1, 1, 5'd0, 5'd0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) begin
      beat(0, "R5");
      beat(1, "R5");
    end

    // R6: zero-length descriptors
    desc(32'h10, 32'h20, 30'd0, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R6");
    #1 ready_chk("R6", 1'b0, 1'b0);
    desc(32'h10, 32'h20, {14'd0, 16'd8}, 32'd0, 1, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R6");
    #1 ready_chk("R6", 1'b0, 1'b0);
    desc(32'h10, 32'h20, {14'd2, 16'd0}, 32'd0, 1, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R6");
    #1 ready_chk("R6", 1'b0, 1'b0);

    // R7: three wait cycles after each beat
    desc(32'h600, 32'h700, 30'd8, 32'd0, 0, 1, 0, 1, 0, 5'd3, 5'd0, 0, 0, "R2");
    beat(0, "R7");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      ready_chk("R7", 1'b0, 1'b0);
    end
    @(negedge clk); #1;
    ready_chk("R7", 1'b1, 1'b1);
    beat(1, "R7");
    beat(0, "R7");
    beat(1, "R7");

    // R8: request line 5 gates reads only
    preq = 32'h0;
    desc(32'h900, 32'h980, 30'd4, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd5, 1, 0, "R2");
    #1;
    chk("R8", "sel_req low", {31'd0, sel_req}, 32'd0);
    ready_chk("R8", 1'b0, 1'b1);
    preq = 32'h40;
    #1;
    chk("R8", "other line", {31'd0, rd_ready}, 32'd0);
    preq = 32'h20;
    #1;
    chk("R8", "sel_req high", {31'd0, sel_req}, 32'd1);
    ready_chk("R8", 1'b1, 1'b1);
    beat(0, "R8");
    beat(1, "R8");
    // R8: request line 5 gates writes only
    preq = 32'h0;
    desc(32'h900, 32'h980, 30'd4, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd5, 0, 1, "R2");
    #1 ready_chk("R8", 1'b1, 1'b0);
    beat(0, "R8");
    preq = 32'h20;
    beat(1, "R8");
    // R8: select 0 is unpaced
    preq = 32'h0;
    desc(32'h900, 32'h980, 30'd4, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 1, 1, "R2");
    #1;
    chk("R8", "unpaced sel_req", {31'd0, sel_req}, 32'd1);
    ready_chk("R8", 1'b1, 1'b1);

    // R10: reload mid-transfer, linear length using the upper field
    desc(32'h1000, 32'h2000, 30'd16, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R2");
    beat(0, "R10");
    beat(1, "R10");
    desc(32'h3000, 32'h3100, {14'd1, 16'd0}, 32'd0, 0, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0, "R10");
    #1 ready_chk("R10", 1'b1, 1'b1);
    beat(1, "R10");

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule